// File: doc/BRIEF.md
# Single-Vector Interrupt Entry Controller

This block turns 32 level-sensitive interrupt request lines into one exception entry for a small 32-bit processor. Each line is sampled into a pending register, gated by a per-line mask and a global enable bit. When an interrupt is accepted at an instruction boundary, the block redirects fetch to one fixed vector above a programmable exception base. It also writes the address of the next instruction into general register 30, and it parks the global enable in a saved-enable bit before clearing it. All lines share that one vector, so the handler reads the pending and mask registers to find the source.

A return-from-exception pulse copies the saved-enable bit back into the global enable and redirects fetch to the saved address. A small CSR port with a 3-bit select gives access to the control, mask, pending and base registers. All pins are plain control and status pins. The block has no streaming interface, so it has no valid/ready back-pressure.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After reset, the control, mask and base registers read zero, and neither the redirect nor the register-30 write is asserted.
- R2: Pending bit i reads the level of request line i as it was sampled at the previous clock edge.
- R3: A CSR write to the pending register has no lasting effect. A later read still shows the line levels.
- R4: An interrupt is accepted only when the global enable is 1 and the AND of pending and mask is nonzero. An active line whose mask bit is 0 causes no redirect.
- R5: An accepted interrupt asserts the redirect for exactly one cycle, and only while the instruction-boundary input is 1. The redirect target is base + 0xC0, whichever line caused it.
- R6: In the entry cycle, the block writes register index 30 with the next-instruction address, with its two low bits forced to zero.
- R7: The control register holds the global enable in bit 0 and the saved enable in bit 1. Entry copies bit 0 into bit 1 and clears bit 0.
- R8: While the global enable is 0, no further redirect occurs, even if masked-in lines stay active.
- R9: A return-from-exception pulse copies the saved enable into the global enable. In the same cycle it asserts the redirect with the saved entry address as the target.
- R10: The CSR select codes are 0 = control, 1 = mask, 2 = pending and 3 = base. Codes 4 to 7 read zero. Writes take effect at the next clock edge. Bits 7:0 of the base always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 32 | Level-sensitive interrupt requests |
| insn_boundary | input | 1 | High when an instruction boundary allows entry |
| next_pc | input | 32 | Address of the next instruction to execute |
| eret_pulse | input | 1 | Return-from-exception strobe |
| csr_sel | input | 3 | CSR select |
| csr_we | input | 1 | CSR write enable |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data (combinational) |
| redirect_valid | output | 1 | Fetch redirect strobe |
| redirect_target | output | 32 | Fetch redirect address |
| ea_we | output | 1 | Write strobe for the saved exception address |
| ea_waddr | output | 5 | Register index written (30) |
| ea_wdata | output | 32 | Saved exception address |

## Verification
The case hardest to reach is a line that is still active after entry while the enable is cleared: the one-cycle redirect must not repeat. The bench holds a masked-in line high for many cycles after entry. Its scoreboard flags any redirect for which it queued no expectation. The bench also holds the boundary input low while a request is already registered, and it expects the redirect only in the cycle the boundary rises.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_MASK = 3'd1,
    SEL_PEND = 3'd2,
    SEL_BASE = 3'd3
  } csr_sel_e;

  localparam int unsigned EA_REG_IDX = 30;
  localparam int unsigned REG_IDX_W  = 5;
endpackage

// File: rtl/irq_pending_unit.sv
module irq_pending_unit #(
  parameter int unsigned NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic [NUM_IRQ-1:0] mask,
  input  logic               gie,
  output logic [NUM_IRQ-1:0] pend_q,
  output logic               req_q
);
  // Level sampling: pending mirrors the lines, software cannot override it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      req_q  <= 1'b0;
    end else begin
      pend_q <= irq_lines;
      req_q  <= gie && ((pend_q & mask) != '0);
    end
  end
endmodule

// File: rtl/irq_csr_file.sv
module irq_csr_file
  import irq_entry_pkg::*;
#(
  parameter int unsigned NUM_IRQ        = 32,
  parameter int unsigned XLEN           = 32,
  parameter int unsigned BASE_ZERO_BITS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         csr_sel,
  input  logic               csr_we,
  input  logic [XLEN-1:0]    csr_wdata,
  input  logic               take,
  input  logic               eret,
  input  logic [NUM_IRQ-1:0] pend,
  output logic [XLEN-1:0]    csr_rdata,
  output logic [NUM_IRQ-1:0] mask_q,
  output logic               gie_q,
  output logic               eie_q,
  output logic [XLEN-1:0]    base_q
);
  localparam logic [XLEN-1:0] BASE_KEEP =
    ~((XLEN'(1) << BASE_ZERO_BITS) - XLEN'(1));

  csr_sel_e sel;
  assign sel = csr_sel_e'(csr_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      eie_q  <= 1'b0;
      mask_q <= '0;
      base_q <= '0;
    end else begin
      if (take) begin
        eie_q <= gie_q;
        gie_q <= 1'b0;
      end else if (eret) begin
        gie_q <= eie_q;
      end else if (csr_we && sel == SEL_CTRL) begin
        gie_q <= csr_wdata[0];
        eie_q <= csr_wdata[1];
      end
      if (csr_we && sel == SEL_MASK) mask_q <= csr_wdata[NUM_IRQ-1:0];
      if (csr_we && sel == SEL_BASE) base_q <= csr_wdata & BASE_KEEP;
    end
  end

  always_comb begin
    csr_rdata = '0;
    unique case (csr_sel)
      SEL_CTRL: csr_rdata[1:0] = {eie_q, gie_q};
      SEL_MASK: csr_rdata[NUM_IRQ-1:0] = mask_q;
      SEL_PEND: csr_rdata[NUM_IRQ-1:0] = pend;
      SEL_BASE: csr_rdata = base_q;
      default:  csr_rdata = '0;
    endcase
  end

  AST_ENTRY_SAVES_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!gie_q && eie_q == $past(gie_q))); // R7
  AST_ERET_RESTORES_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !take) |=> (gie_q == $past(eie_q))); // R9
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
  import irq_entry_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter logic [31:0] VEC_OFFSET = 32'h0000_00C0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic                 gie,
  input  logic                 insn_boundary,
  input  logic                 eret,
  input  logic [XLEN-1:0]      next_pc,
  input  logic [XLEN-1:0]      base,
  output logic                 take,
  output logic                 redirect_valid,
  output logic [XLEN-1:0]      redirect_target,
  output logic                 ea_we,
  output logic [REG_IDX_W-1:0] ea_waddr,
  output logic [XLEN-1:0]      ea_wdata
);
  localparam logic [XLEN-1:0] WORD_KEEP = ~XLEN'(3);

  logic [XLEN-1:0] ea_q;
  logic [XLEN-1:0] ret_addr;

  assign ret_addr = next_pc & WORD_KEEP;
  // Return has priority; entry needs a registered request and a live enable.
  assign take = req && gie && insn_boundary && !eret;

  always_ff @(posedge clk) begin
    if (!rst_n) ea_q <= '0;
    else if (take) ea_q <= ret_addr;
  end

  assign redirect_valid  = take || eret;
  assign redirect_target = take ? (base + XLEN'(VEC_OFFSET)) : ea_q;
  assign ea_we    = take;
  assign ea_waddr = REG_IDX_W'(EA_REG_IDX);
  assign ea_wdata = ret_addr;

  AST_TAKE_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (gie && insn_boundary)); // R4
  AST_SINGLE_ENTRY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take); // R8
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int unsigned NUM_IRQ        = 32,
  parameter int unsigned XLEN           = 32,
  parameter int unsigned BASE_ZERO_BITS = 8,
  parameter logic [31:0] VEC_OFFSET     = 32'h0000_00C0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic               insn_boundary,
  input  logic [XLEN-1:0]    next_pc,
  input  logic               eret_pulse,
  input  logic [2:0]         csr_sel,
  input  logic               csr_we,
  input  logic [XLEN-1:0]    csr_wdata,
  output logic [XLEN-1:0]    csr_rdata,
  output logic               redirect_valid,
  output logic [XLEN-1:0]    redirect_target,
  output logic               ea_we,
  output logic [4:0]         ea_waddr,
  output logic [XLEN-1:0]    ea_wdata
);
  logic [NUM_IRQ-1:0] pend, mask;
  logic               req, gie, eie, take;
  logic [XLEN-1:0]    base;

  irq_pending_unit #(.NUM_IRQ(NUM_IRQ)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .mask(mask),
    .gie(gie), .pend_q(pend), .req_q(req)
  );

  irq_csr_file #(.NUM_IRQ(NUM_IRQ), .XLEN(XLEN), .BASE_ZERO_BITS(BASE_ZERO_BITS)) u_csr (
    .clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .take(take), .eret(eret_pulse), .pend(pend),
    .csr_rdata(csr_rdata), .mask_q(mask), .gie_q(gie), .eie_q(eie), .base_q(base)
  );

  irq_vector_gen #(.XLEN(XLEN), .VEC_OFFSET(VEC_OFFSET)) u_vec (
    .clk(clk), .rst_n(rst_n), .req(req), .gie(gie), .insn_boundary(insn_boundary),
    .eret(eret_pulse), .next_pc(next_pc), .base(base), .take(take),
    .redirect_valid(redirect_valid), .redirect_target(redirect_target),
    .ea_we(ea_we), .ea_waddr(ea_waddr), .ea_wdata(ea_wdata)
  );

  AST_ERET_NOT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_pulse && !eie) |=> !gie); // R9
endmodule

// File: tb/test_irq_entry_ctrl.sv
`timescale 1ns/1ps
module test_irq_entry_ctrl;
  typedef struct packed {
    logic [31:0] tgt;
    logic        entry;
    logic [31:0] ea;
  } exp_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic        insn_boundary = 1'b1;
  logic [31:0] next_pc = '0;
  logic        eret_pulse = 1'b0;
  logic [2:0]  csr_sel = '0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata, redirect_target, ea_wdata;
  logic        redirect_valid, ea_we;
  logic [4:0]  ea_waddr;

  int   checks = 0, fails = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  irq_entry_ctrl i_irq_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .insn_boundary(insn_boundary),
    .next_pc(next_pc), .eret_pulse(eret_pulse), .csr_sel(csr_sel), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .redirect_valid(redirect_valid),
    .redirect_target(redirect_target), .ea_we(ea_we), .ea_waddr(ea_waddr),
    .ea_wdata(ea_wdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic csr_wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    csr_sel = s; csr_we = 1'b1; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_rd(input logic [2:0] s, input logic [31:0] exp, input string req);
    @(negedge clk);
    csr_sel = s;
    #5;
    chk(csr_rdata == exp, req, csr_rdata, exp);
  endtask

  task automatic eret_go(input logic [31:0] ea);
    @(negedge clk);
    q.push_back('{tgt: ea, entry: 1'b0, ea: 32'h0});
    eret_pulse = 1'b1;
    @(negedge clk);
    eret_pulse = 1'b0;
  endtask

  // Monitor: every redirect must match the oldest queued expectation.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rst_n && redirect_valid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R8 unexpected redirect", redirect_target, 32'h0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(redirect_target == e.tgt, "R5/R9 redirect target", redirect_target, e.tgt);
          chk(ea_we == e.entry, "R6 ea write strobe", {31'b0, ea_we}, {31'b0, e.entry});
          if (e.entry) begin
            chk(ea_waddr == 5'd30, "R6 ea register index", {27'b0, ea_waddr}, 32'd30);
            chk(ea_wdata == e.ea, "R6 saved address", ea_wdata, e.ea);
          end
        end
      end else if (rst_n && ea_we) begin
        chk(1'b0, "R6 write without redirect", ea_wdata, 32'h0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1); #5;
    chk(redirect_valid == 1'b0, "R1 no redirect after reset", {31'b0, redirect_valid}, 32'h0);
    csr_rd(3'd0, 32'h0, "R1 control reset");
    csr_rd(3'd1, 32'h0, "R1 mask reset");
    csr_rd(3'd3, 32'h0, "R1 base reset");

    csr_wr(3'd3, 32'h1234_56FF);
    csr_rd(3'd3, 32'h1234_5600, "R10 base low bits zero");
    csr_rd(3'd5, 32'h0, "R10 unused select reads zero");

    @(negedge clk); irq_lines = 32'h0000_0080;
    csr_rd(3'd2, 32'h0000_0080, "R2 pending follows line 7");
    csr_wr(3'd2, 32'hFFFF_FFFF);
    csr_rd(3'd2, 32'h0000_0080, "R3 pending write ignored");
    @(negedge clk); irq_lines = '0;

    csr_wr(3'd1, 32'h0000_0020);
    csr_wr(3'd0, 32'h0000_0001);
    csr_rd(3'd1, 32'h0000_0020, "R10 mask write");
    @(negedge clk); irq_lines = 32'h0000_0008;
    tick(5);
    csr_rd(3'd0, 32'h1, "R4 masked line leaves enable set");
    @(negedge clk); irq_lines = '0;
    tick(2);

    @(negedge clk);
    next_pc = 32'h0000_4007;
    q.push_back('{tgt: 32'h1234_56C0, entry: 1'b1, ea: 32'h0000_4004});
    irq_lines = 32'h0000_0020;
    tick(5);
    csr_rd(3'd0, 32'h2, "R7 entry moves enable to saved bit");
    tick(6);
    chk(q.size() == 0, "R8 single entry while line held", q.size(), 0);
    @(negedge clk); irq_lines = '0;
    tick(3);
    eret_go(32'h0000_4004);
    csr_rd(3'd0, 32'h3, "R9 enable restored");

    @(negedge clk);
    insn_boundary = 1'b0;
    next_pc = 32'h0000_8000;
    irq_lines = 32'h8000_0020;
    tick(5);
    @(negedge clk);
    q.push_back('{tgt: 32'h1234_56C0, entry: 1'b1, ea: 32'h0000_8000});
    insn_boundary = 1'b1;
    tick(3);
    chk(q.size() == 0, "R5 entry waits for boundary", q.size(), 0);
    csr_rd(3'd0, 32'h2, "R7 second entry");
    @(negedge clk); irq_lines = '0;
    tick(3);
    eret_go(32'h0000_8000);
    tick(2);
    chk(q.size() == 0, "R9 all redirects seen", q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule